// File: doc/BRIEF.md
# SPI Slave Hold-Pause Controller

This block is the sequencing front end of a serial-peripheral slave memory interface. It runs on a fast system clock and samples three slow pins: chip-select (active low), the serial clock, and a hold request (active low). Each pin passes through a multi-flop synchronizer. From the synchronized levels the block decides whether the current transfer is paused. It then produces a one-cycle shift strobe for the data shifter, an output-enable for the serial data-out driver, and an interface reset whenever the device is deselected.

The hold request can only pause or resume a transfer while the serial clock is in its low phase. A request that changes while the clock is high waits until the clock next drops. While paused, serial clock edges are ignored and the data-out driver is released. A 3-bit bit-position counter advances on serial clock rising edges. Its value is frozen during a pause, so a resumed transfer continues at the same bit. Deselecting the device clears both the counter and the paused state.

Top module: `spi_hold_ctrl`

## Requirements
- R1: While chip-select is high (deselected), iface_rst is 1, bit_pos is 0, paused is 0 and so_oe is 0.
- R2: While selected and not paused, each serial clock rising edge increments bit_pos by one, and bit_pos wraps from 7 to 0.
- R3: With chip-select low, hold_n low while the serial clock is low makes paused go to 1.
- R4: If hold_n goes low while the serial clock is high, paused stays 0 until the serial clock next goes low, and then becomes 1.
- R5: With hold_n high while the serial clock is low, paused returns to 0. If hold_n rises while the serial clock is high, paused stays 1 until the serial clock next goes low.
- R6: While paused, serial clock edges produce no shift strobe and bit_pos keeps its value.
- R7: so_oe is 1 exactly when the device is selected, not paused, and out_phase is 1. It is 0 throughout a pause.
- R8: Raising chip-select during a pause clears paused and resets bit_pos to 0.
- R9: Selecting the device again while hold_n is still low does not resume the transfer: paused returns to 1. Only hold_n high together with chip-select low resumes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n_in | input | 1 | Chip-select pin, active low, asynchronous |
| sck_in | input | 1 | Serial clock pin, asynchronous |
| hold_n_in | input | 1 | Hold request pin, active low, asynchronous |
| out_phase | input | 1 | High while the current transfer is driving data out (system clock domain) |
| paused | output | 1 | Transfer is held |
| shift_en | output | 1 | One-cycle strobe: shift one serial bit |
| so_oe | output | 1 | Output-enable for the serial data-out driver |
| iface_rst | output | 1 | Interface reset, high while deselected |
| bit_pos | output | 3 | Bit position within the current byte |

## Verification
A wrong hold state shows at the ports within a few system clocks of the synchronized pin change. so_oe and paused disagree with the expected pause at once. A missed deferral shows paused changing while the serial clock is still high. A counter that moves during a pause, or that survives deselection, is only visible as a wrong bit_pos after the next clock low phase or the next selection. For that reason the bench reads bit_pos after every pause exit and after every reselection.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_HOLD = 1'b1
  } hold_state_e;

  localparam int unsigned PIN_COUNT = 3;
  localparam int unsigned PIN_CS    = 0;
  localparam int unsigned PIN_SCK   = 1;
  localparam int unsigned PIN_HOLD  = 2;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] chain_nxt;

  generate
    if (STAGES == 1) begin : g_one
      assign chain_nxt = d;
    end else begin : g_many
      assign chain_nxt = {chain[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= chain_nxt;
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
  import spi_hold_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic selected,
  input  logic sck_lvl,
  input  logic hold_req,
  output logic paused
);
  hold_state_e state_q, state_d;

  // Changes of the pause state are only allowed in the clock-low phase.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (selected && hold_req && !sck_lvl) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (!selected)                      state_d = ST_RUN;
        else if (!hold_req && !sck_lvl)     state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign paused = (state_q == ST_HOLD);
endmodule

// File: rtl/spi_hold_bitcnt.sv
module spi_hold_bitcnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | step;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n_in,
  input  logic             sck_in,
  input  logic             hold_n_in,
  input  logic             out_phase,
  output logic             paused,
  output logic             shift_en,
  output logic             so_oe,
  output logic             iface_rst,
  output logic [CNT_W-1:0] bit_pos
);
  localparam logic [PIN_COUNT-1:0] SYNC_RST = 3'b101;

  // Reset release synchronizer
  logic [1:0] rst_pipe;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  // Pin synchronizers
  logic [PIN_COUNT-1:0] pin_raw;
  logic [PIN_COUNT-1:0] pin_s;

  assign pin_raw[PIN_CS]   = cs_n_in;
  assign pin_raw[PIN_SCK]  = sck_in;
  assign pin_raw[PIN_HOLD] = hold_n_in;

  generate
    for (genvar gi = 0; gi < PIN_COUNT; gi++) begin : g_sync
      spi_hold_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(SYNC_RST[gi])
      ) u_sync (
        .clk  (clk),
        .rst_n(srst_n),
        .d    (pin_raw[gi]),
        .q    (pin_s[gi])
      );
    end
  endgenerate

  logic cs_s, sck_s, hold_s;
  assign cs_s   = pin_s[PIN_CS];
  assign sck_s  = pin_s[PIN_SCK];
  assign hold_s = pin_s[PIN_HOLD];

  // Serial clock edge detection
  logic sck_q;
  logic sck_rise;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) sck_q <= 1'b0;
    else         sck_q <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_q;

  // Pause state
  logic selected;
  assign selected = ~cs_s;

  spi_hold_fsm u_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .selected(selected),
    .sck_lvl (sck_s),
    .hold_req(~hold_s),
    .paused  (paused)
  );

  // Gated shift strobe and bit position
  assign shift_en  = sck_rise & selected & ~paused;
  assign iface_rst = cs_s;

  spi_hold_bitcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(srst_n),
    .clr  (iface_rst),
    .step (shift_en),
    .cnt  (bit_pos)
  );

  // Data-out driver enable
  assign so_oe = selected & ~paused & out_phase;
endmodule

// File: rtl/spi_hold_ctrl_chk.sv
module spi_hold_ctrl_chk #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             paused,
  input logic             shift_en,
  input logic             so_oe,
  input logic             iface_rst,
  input logic [CNT_W-1:0] bit_pos,
  input logic             sck_s,
  input logic             hold_s
);
  assert_oe_off_in_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> !paused && !iface_rst);

  assert_pos_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    paused && !iface_rst |=> $stable(bit_pos));

  assert_deselect_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    iface_rst |=> bit_pos == '0 && !paused);

  assert_entry_clock_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(paused) |-> !$past(sck_s) && !$past(hold_s));

  assert_exit_clock_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(paused) && !$past(iface_rst) |-> !$past(sck_s) && $past(hold_s));

  assert_step_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> bit_pos == $past(bit_pos) + CNT_W'(1));
endmodule

bind spi_hold_ctrl spi_hold_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .paused   (paused),
  .shift_en (shift_en),
  .so_oe    (so_oe),
  .iface_rst(iface_rst),
  .bit_pos  (bit_pos),
  .sck_s    (sck_s),
  .hold_s   (hold_s)
);

// File: tb/spi_hold_ctrl_bench.sv
module spi_hold_ctrl_bench;
  logic       clk;
  logic       rst_n;
  logic       cs_n_in, sck_in, hold_n_in, out_phase;
  logic       paused, shift_en, so_oe, iface_rst;
  logic [2:0] bit_pos;

  spi_hold_ctrl u_spi_hold_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n_in  (cs_n_in),
    .sck_in   (sck_in),
    .hold_n_in(hold_n_in),
    .out_phase(out_phase),
    .paused   (paused),
    .shift_en (shift_en),
    .so_oe    (so_oe),
    .iface_rst(iface_rst),
    .bit_pos  (bit_pos)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    string      tag;
    logic       p;
    logic       oe;
    logic [2:0] pos;
    logic       rst;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 1'b0;
  logic [2:0] exp_pos = 3'd0;

  // Monitor: compares each queued expectation at the next falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (paused !== e.p || so_oe !== e.oe || bit_pos !== e.pos || iface_rst !== e.rst) begin
          n_bad++;
          $display("FAIL %s: paused/so_oe/bit_pos/iface_rst actual %b/%b/%0d/%b expected %b/%b/%0d/%b",
                   e.tag, paused, so_oe, bit_pos, iface_rst, e.p, e.oe, e.pos, e.rst);
        end
      end
    end
  end

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  task automatic expect_state(input string tag, input logic p, input logic oe,
                              input logic [2:0] pos, input logic rst);
    exp_t e;
    e.tag = tag; e.p = p; e.oe = oe; e.pos = pos; e.rst = rst;
    exp_q.push_back(e);
    @(posedge clk);
  endtask

  task automatic sck_pulse(input bit counts);
    sck_in = 1'b1;
    repeat (8) @(posedge clk);
    sck_in = 1'b0;
    repeat (8) @(posedge clk);
    if (counts) exp_pos = exp_pos + 3'd1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n_in = 1'b1; sck_in = 1'b0; hold_n_in = 1'b1; out_phase = 1'b1;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    settle();
    expect_state("R1 reset deselected", 0, 0, 0, 1);

    cs_n_in = 1'b0; settle();
    expect_state("R7 selected output phase", 0, 1, 0, 0);

    for (int i = 0; i < 3; i++) sck_pulse(1);
    settle();
    expect_state("R2 three edges", 0, 1, exp_pos, 0);

    hold_n_in = 1'b0; settle();
    expect_state("R3 hold in clock low", 1, 0, exp_pos, 0);

    for (int i = 0; i < 2; i++) sck_pulse(0);
    expect_state("R6 edges ignored in hold", 1, 0, exp_pos, 0);

    sck_in = 1'b1; settle();
    expect_state("R6 clock high in hold", 1, 0, exp_pos, 0);
    hold_n_in = 1'b1; settle();
    expect_state("R5 release deferred while clock high", 1, 0, exp_pos, 0);
    sck_in = 1'b0; settle();
    expect_state("R5 release at clock low", 0, 1, exp_pos, 0);

    sck_pulse(1);
    expect_state("R6 resume at same bit", 0, 1, exp_pos, 0);

    sck_in = 1'b1; settle(); exp_pos = exp_pos + 3'd1;
    expect_state("R2 edge before late hold", 0, 1, exp_pos, 0);
    hold_n_in = 1'b0; settle();
    expect_state("R4 entry deferred while clock high", 0, 1, exp_pos, 0);
    sck_in = 1'b0; settle();
    expect_state("R4 entry at clock low", 1, 0, exp_pos, 0);

    cs_n_in = 1'b1; settle(); exp_pos = 3'd0;
    expect_state("R8 deselect in hold", 0, 0, 0, 1);

    cs_n_in = 1'b0; settle();
    expect_state("R9 reselect with hold low", 1, 0, 0, 0);
    hold_n_in = 1'b1; settle();
    expect_state("R9 resume after hold high", 0, 1, 0, 0);

    for (int i = 0; i < 9; i++) sck_pulse(1);
    settle();
    expect_state("R2 wrap past seven", 0, 1, exp_pos, 0);

    out_phase = 1'b0; settle();
    expect_state("R7 input phase", 0, 0, exp_pos, 0);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule